// File: doc/BRIEF.md
# Burst-Addressed Synchronous SRAM

This block is a clocked, synthesizable model of a single-port synchronous SRAM. Each word is 18 bits wide and split into two byte lanes, each lane being 8 data bits and a parity bit. On every rising clock edge the control logic sorts the sampled inputs into one of these cycles: deselect, begin read, continue read, suspend read, begin write, continue write, suspend write, or no operation while the sleep input is high. Two address strobes start new accesses, and each follows its own rules. The processor strobe always opens a read. The controller strobe opens a read or a write, depending on the write controls.

After an access has started, the advance input steps an internal burst counter. The counter wraps inside an aligned group of four words. Holding advance inactive keeps the burst on the current word. The shared data bus is tri-stated. The array drives it only during read cycles, and only while the output enable is low. The output enable acts on the drivers combinationally, with no clock involved.

Top module: `sram_burst_top`

## Requirements
- R1: After reset the block is deselected: the data bus is high impedance even with output enable low, until an access starts.
- R2: A start by either strobe while `ceFirstN` is high, `ceSecond` is low or `ceThirdN` is high deselects the block. No write happens, and the bus is high impedance from that edge on. Cycles with no strobe keep the block deselected.
- R3: A start by the processor strobe (`procStrobeN` low with `ceFirstN` low) is always a read. This holds even when `globalWrN`, `byteWrEnN` and `laneWrN` request a write, and the array is left unchanged.
- R4: A controller-strobe start with the write term active writes the bus data at the external address on that same edge. After a processor-strobe start, a write on the following edge goes to the loaded address.
- R5: Lane 0 is bus bits 8:0 and lane 1 is bus bits 17:9, where bit 8 and bit 17 are the lane parity bits. With `globalWrN` high, `byteWrEnN` low and a lane's `laneWrN` bit low, that lane alone is written. With `byteWrEnN` high, the lane inputs have no effect and the cycle is a read.
- R6: `globalWrN` low writes both lanes, whatever `byteWrEnN` and `laneWrN` are.
- R7: In a cycle with no start, `advanceN` low moves to the next address. Only the low two address bits increment, and they wrap from 3 to 0.
- R8: In a cycle with no start, `advanceN` high keeps the current address.
- R9: The output enable is not clocked. During a read, the bus goes high impedance as soon as `outEnN` is high and shows the stored word as soon as it is low.
- R10: After a write cycle the bus is not driven, even with `outEnN` low.
- R11: While `sleep` is high, every other input is ignored. No read or write starts, and the bus is high impedance.
- R12: The processor strobe is ignored when `ceFirstN` is high. The cycle proceeds under the other controls, for example as a burst continue.
- R13: A read cycle decoded at an edge puts its word on the bus from that edge until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge samples all inputs except outEnN |
| rstN | input | 1 | Active-low synchronous reset of control state |
| addrIn | input | ADDR_W | External word address |
| ceFirstN | input | 1 | Chip enable, active low; also gates the processor strobe |
| ceSecond | input | 1 | Chip enable, active high |
| ceThirdN | input | 1 | Chip enable, active low |
| procStrobeN | input | 1 | Processor address strobe, active low |
| ctrlStrobeN | input | 1 | Controller address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| globalWrN | input | 1 | Write all lanes, active low |
| byteWrEnN | input | 1 | Byte-write enable, active low |
| laneWrN | input | 2 | Per-lane write selects, active low |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep, active high; no operation while set |
| dataIo | inout | 18 | Tri-stated data bus |

## Verification
The bench starts a burst at an address whose low bits are 2 and advances it three times. A counter that carried into bit 2 would return word 8 instead of word 4, and a counter that ignored advance would return the same word each time. It also requests a write together with a processor-strobe start and during deselect or sleep, and then reads those locations back. A decoder that let either case write would leave the array corrupted. Further checks toggle the output enable between clock edges, look at the bus right after a write with the enable low, and give the processor strobe while `ceFirstN` is high in the middle of a burst. These catch a clocked enable, a driver that is not masked during writes, and a strobe that restarts the burst at the external address.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  localparam int LANE_CNT = 2;
  localparam int LANE_W   = 9;
  localparam int WORD_W   = LANE_CNT * LANE_W;

  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_RD_BEGIN,
    CYC_RD_CONT,
    CYC_RD_HOLD,
    CYC_WR_BEGIN,
    CYC_WR_CONT,
    CYC_WR_HOLD
  } cycleKindT;

  typedef struct packed {
    cycleKindT           kind;
    logic                doRead;
    logic                doWrite;
    logic [LANE_CNT-1:0] laneWe;
  } memStrobeT;
endpackage

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic                ceFirstN,
  input  logic                ceSecond,
  input  logic                ceThirdN,
  input  logic                procStrobeN,
  input  logic                ctrlStrobeN,
  input  logic                advanceN,
  input  logic                globalWrN,
  input  logic                byteWrEnN,
  input  logic [LANE_CNT-1:0] laneWrN,
  input  logic                sleep,
  output memStrobeT           strobes,
  output logic [ADDR_W-1:0]   memAddr
);
  localparam int HIGH_W = ADDR_W - BURST_W;

  logic [ADDR_W-1:0] addrReg;
  logic              active;
  logic              wrTerm;
  logic              selected;
  logic              procStart;
  logic              ctrlStart;
  logic [ADDR_W-1:0] nextAddr;
  cycleKindT         kind;

  assign wrTerm    = !globalWrN || (!byteWrEnN && !(&laneWrN));
  assign selected  = !ceFirstN && ceSecond && !ceThirdN;
  assign procStart = !procStrobeN && !ceFirstN;
  assign ctrlStart = !ctrlStrobeN;
  assign nextAddr  = {addrReg[ADDR_W-1:BURST_W],
                      addrReg[BURST_W-1:0] + BURST_W'(1)};

  always_comb begin
    kind    = CYC_IDLE;
    memAddr = addrReg;
    if (sleep) begin
      kind = CYC_IDLE;
    end else if (procStart) begin
      kind    = selected ? CYC_RD_BEGIN : CYC_DESEL;
      memAddr = addrIn;
    end else if (ctrlStart) begin
      memAddr = addrIn;
      if (!selected)   kind = CYC_DESEL;
      else if (wrTerm) kind = CYC_WR_BEGIN;
      else             kind = CYC_RD_BEGIN;
    end else if (!active) begin
      kind = CYC_DESEL;
    end else if (!advanceN) begin
      kind    = wrTerm ? CYC_WR_CONT : CYC_RD_CONT;
      memAddr = nextAddr;
    end else begin
      kind = wrTerm ? CYC_WR_HOLD : CYC_RD_HOLD;
    end
  end

  always_comb begin
    strobes.kind    = kind;
    strobes.doRead  = (kind == CYC_RD_BEGIN) || (kind == CYC_RD_CONT) ||
                      (kind == CYC_RD_HOLD);
    strobes.doWrite = (kind == CYC_WR_BEGIN) || (kind == CYC_WR_CONT) ||
                      (kind == CYC_WR_HOLD);
  end

  for (genvar lane = 0; lane < LANE_CNT; lane++) begin : g_laneWe
    assign strobes.laneWe[lane] = strobes.doWrite &&
      (!globalWrN || (!byteWrEnN && !laneWrN[lane]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      active  <= 1'b0;
    end else begin
      case (kind)
        CYC_IDLE:  ;
        CYC_DESEL: active <= 1'b0;
        default: begin
          active  <= 1'b1;
          addrReg <= memAddr;
        end
      endcase
    end
  end

  // R3: a processor-strobe start never writes
  p_proc_reads_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && procStart) |-> !strobes.doWrite);

  // R11: sleep leaves burst state untouched
  p_sleep_holds_r11: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> ($stable(addrReg) && $stable(active)));

  // R7: an advance never carries out of the burst group
  p_burst_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (kind == CYC_RD_CONT || kind == CYC_WR_CONT) |=>
      (addrReg[ADDR_W-1:BURST_W] == $past(addrReg[ADDR_W-1:BURST_W])));

  // R8: a suspend keeps the address
  p_suspend_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (kind == CYC_RD_HOLD || kind == CYC_WR_HOLD) |=> $stable(addrReg));

  logic [HIGH_W-1:0] unusedHigh;
  assign unusedHigh = nextAddr[ADDR_W-1:BURST_W];
endmodule

// File: rtl/sram_burst_datapath.sv
module sram_burst_datapath
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobeT         strobes,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [WORD_W-1:0] busIn,
  output logic [WORD_W-1:0] rdData,
  output logic              readPhase
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int lane = 0; lane < LANE_CNT; lane++) begin
      if (strobes.laneWe[lane])
        mem[memAddr][lane*LANE_W +: LANE_W] <= busIn[lane*LANE_W +: LANE_W];
    end
    if (strobes.doRead) rdData <= mem[memAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) readPhase <= 1'b0;
    else       readPhase <= strobes.doRead;
  end

  // R2: a deselect releases the bus drivers
  p_desel_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.kind == CYC_DESEL) |=> !readPhase);

  // R10: a write cycle leaves the drivers off
  p_write_mask_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doWrite |=> !readPhase);

  // R5: lane writes only occur in write cycles
  p_lane_only_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.laneWe != '0) |-> strobes.doWrite);
endmodule

// File: rtl/sram_burst_top.sv
module sram_burst_top
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              ceFirstN,
  input  logic              ceSecond,
  input  logic              ceThirdN,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [1:0]        laneWrN,
  input  logic              outEnN,
  input  logic              sleep,
  inout  wire  [17:0]       dataIo
);
  memStrobeT         strobes;
  logic [ADDR_W-1:0] memAddr;
  logic [WORD_W-1:0] rdData;
  logic              readPhase;
  logic              busDrive;

  sram_burst_ctrl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn),
    .ceFirstN(ceFirstN), .ceSecond(ceSecond), .ceThirdN(ceThirdN),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .globalWrN(globalWrN), .byteWrEnN(byteWrEnN),
    .laneWrN(laneWrN), .sleep(sleep),
    .strobes(strobes), .memAddr(memAddr)
  );

  sram_burst_datapath #(.ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .memAddr(memAddr),
    .busIn(dataIo), .rdData(rdData), .readPhase(readPhase)
  );

  assign busDrive = readPhase && !outEnN;
  assign dataIo   = busDrive ? rdData : 'z;
endmodule

// File: tb/tb_sram_burst_top.sv
module tb_sram_burst_top;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 6;

  logic clk = 1'b0;
  logic rstN;
  logic [ADDR_W-1:0] addrIn;
  logic ceFirstN, ceSecond, ceThirdN, procStrobeN, ctrlStrobeN, advanceN;
  logic globalWrN, byteWrEnN, outEnN, sleep;
  logic [1:0] laneWrN;
  wire  [17:0] dataIo;
  logic tbDrv;
  logic [17:0] tbVal;
  logic [17:0] shadow [16];
  int checks = 0;
  int errs   = 0;

  assign dataIo = tbDrv ? tbVal : 'z;

  always #(CLK_P/2) clk = ~clk;

  sram_burst_top #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn),
    .ceFirstN(ceFirstN), .ceSecond(ceSecond), .ceThirdN(ceThirdN),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .globalWrN(globalWrN), .byteWrEnN(byteWrEnN),
    .laneWrN(laneWrN), .outEnN(outEnN), .sleep(sleep), .dataIo(dataIo)
  );

  function automatic logic [17:0] pat(int i);
    return 18'(i * 18'h01357 + 18'h002A5);
  endfunction

  task automatic check(string tag, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic setIdle();
    addrIn = '0; ceFirstN = 0; ceSecond = 1; ceThirdN = 0;
    procStrobeN = 1; ctrlStrobeN = 1; advanceN = 1;
    globalWrN = 1; byteWrEnN = 1; laneWrN = 2'b11;
    outEnN = 1; sleep = 0; tbDrv = 0; tbVal = '0;
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic ctrlWrite(int a, logic [17:0] d);
    setIdle();
    addrIn = ADDR_W'(a); ctrlStrobeN = 0; globalWrN = 0;
    tbDrv = 1; tbVal = d;
    step();
    shadow[a] = d;
    setIdle();
  endtask

  task automatic procRead(string tag, int a);
    setIdle();
    addrIn = ADDR_W'(a); procStrobeN = 0; outEnN = 0;
    step();
    procStrobeN = 1;
    check(tag, dataIo, shadow[a]);
  endtask

  task automatic testReset();
    setIdle();
    rstN = 0; outEnN = 0;
    repeat (3) step();
    rstN = 1;
    step();
    check("R1 bus after reset", dataIo, 'z);
    setIdle();
  endtask

  task automatic testFill();
    for (int i = 0; i < 16; i++) ctrlWrite(i, pat(i));
    procRead("R4 ctrl write readback word 5", 5);
    procRead("R13 read word 14", 14);
    outEnN = 0;
    @(negedge clk);
    check("R13 data held mid cycle", dataIo, shadow[14]);
    #3;
    setIdle();
  endtask

  task automatic testBurst();
    procRead("R7 burst start word 6", 6);
    advanceN = 0; outEnN = 0;
    step(); check("R7 advance to 7", dataIo, shadow[7]);
    step(); check("R7 wrap to 4", dataIo, shadow[4]);
    step(); check("R7 advance to 5", dataIo, shadow[5]);
    advanceN = 1;
    step(); check("R8 suspend at 5", dataIo, shadow[5]);
    outEnN = 1; #1;
    check("R9 oe high releases bus", dataIo, 'z);
    outEnN = 0; #1;
    check("R9 oe low drives without clock", dataIo, shadow[5]);
    setIdle();
  endtask

  task automatic testProcIgnoresWrite();
    setIdle();
    addrIn = 3; procStrobeN = 0; globalWrN = 0; byteWrEnN = 0; laneWrN = 2'b00;
    outEnN = 0;
    step();
    check("R3 proc start reads despite write", dataIo, shadow[3]);
    setIdle();
    procRead("R3 array unchanged", 3);
  endtask

  task automatic testProcThenWrite();
    setIdle();
    addrIn = 9; procStrobeN = 0;
    step();
    procStrobeN = 1; globalWrN = 0; tbDrv = 1; tbVal = 18'h2BEEF;
    step();
    shadow[9] = 18'h2BEEF;
    tbDrv = 0; globalWrN = 1; outEnN = 0; #1;
    check("R10 bus idle after write with oe low", dataIo, 'z);
    setIdle();
    procRead("R4 write after proc start", 9);
  endtask

  task automatic testLanes();
    logic [17:0] d;
    d = 18'h3C5A5;
    setIdle();
    addrIn = 12; ctrlStrobeN = 0; byteWrEnN = 0; laneWrN = 2'b10;
    tbDrv = 1; tbVal = d;
    step();
    shadow[12][8:0] = d[8:0];
    setIdle();
    procRead("R5 lane0 only", 12);
    addrIn = 13; ctrlStrobeN = 0; byteWrEnN = 0; laneWrN = 2'b01;
    tbDrv = 1; tbVal = d; procStrobeN = 1; outEnN = 1;
    step();
    shadow[13][17:9] = d[17:9];
    setIdle();
    procRead("R5 lane1 only", 13);
    addrIn = 11; ctrlStrobeN = 0; byteWrEnN = 1; laneWrN = 2'b00;
    tbDrv = 1; tbVal = d; procStrobeN = 1; outEnN = 1;
    step();
    tbDrv = 0; outEnN = 0; #1;
    check("R5 lanes without enable read", dataIo, shadow[11]);
    setIdle();
    procRead("R5 lanes without enable unchanged", 11);
    addrIn = 10; ctrlStrobeN = 0; globalWrN = 0; byteWrEnN = 0; laneWrN = 2'b10;
    tbDrv = 1; tbVal = d; procStrobeN = 1; outEnN = 1;
    step();
    shadow[10] = d;
    setIdle();
    procRead("R6 global writes both lanes", 10);
  endtask

  task automatic deselTry(string tag, logic f, logic s, logic t);
    setIdle();
    addrIn = 2; ctrlStrobeN = 0; globalWrN = 0;
    ceFirstN = f; ceSecond = s; ceThirdN = t;
    tbDrv = 1; tbVal = 18'h15555;
    step();
    setIdle();
    outEnN = 0; #1;
    check(tag, dataIo, 'z);
  endtask

  task automatic testDeselect();
    procRead("R2 prime read", 1);
    deselTry("R2 first enable high", 1, 1, 0);
    deselTry("R2 second enable low", 0, 0, 0);
    deselTry("R2 third enable high", 0, 1, 1);
    advanceN = 0; outEnN = 0;
    step();
    check("R2 stays deselected", dataIo, 'z);
    setIdle();
    addrIn = 1; procStrobeN = 0; ceSecond = 0; outEnN = 0;
    step();
    check("R2 proc start deselected", dataIo, 'z);
    setIdle();
    procRead("R2 no write on deselect", 2);
  endtask

  task automatic testSleep();
    procRead("R11 prime read", 7);
    sleep = 1; addrIn = 8; ctrlStrobeN = 0; globalWrN = 0;
    tbDrv = 1; tbVal = 18'h0F0F0; outEnN = 1;
    step();
    tbDrv = 0; outEnN = 0; #1;
    check("R11 bus idle in sleep", dataIo, 'z);
    setIdle();
    procRead("R11 no write in sleep", 8);
  endtask

  task automatic testProcIgnored();
    procRead("R12 burst start word 8", 8);
    addrIn = 0; procStrobeN = 0; ceFirstN = 1; advanceN = 0; outEnN = 0;
    step();
    check("R12 strobe ignored, burst continues", dataIo, shadow[9]);
    setIdle();
  endtask

  initial begin
    #(CLK_P * 100000);
    errs++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    testReset();
    testFill();
    testBurst();
    testProcIgnoresWrite();
    testProcThenWrite();
    testLanes();
    testDeselect();
    testSleep();
    testProcIgnored();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule